// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from normal execution into an exception handler. When the core raises an exception request with an 8-bit vector number, the sequencer captures the current status word, program counter, supervisor stack pointer and vector base. It then computes the new status word, with supervisor state on and tracing off, before it makes any memory access.

With that state in place it runs a fixed series of 16-bit bus cycles through a request/acknowledge memory port. The port also carries a 3-bit access-space code. The series is three stack pushes, two vector reads and the first handler fetch. When the fetch is acknowledged, the block presents the new program counter, status word and stack pointer and raises a one-cycle done pulse.

The core treats this block as a microsequence. It raises the request, waits for done, and then resumes at the handler. New requests are not accepted while a sequence is running.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `busy`, `done` and `mem_req` are 0 and `new_pc`, `new_sr` and `new_ssp` are 0. Asserting reset during a sequence drops `busy` and `mem_req` at once.
- R2: An accepted request produces exactly six bus cycles, in this order:
  - a write at SSP-2 carrying PC[31:16];
  - a write at SSP-4 carrying PC[15:0];
  - a write at SSP-6 carrying the status word;
  - a read at VBR+4·vector;
  - a read at VBR+4·vector+2;
  - a read at the new PC.
  All address arithmetic wraps modulo 2^32.
- R3: The status word written on the stack is the value captured at request time, unmodified.
- R4: `new_sr` equals the captured status word with bit 13 (supervisor) set and bit 15 (trace) cleared. All other bits are unchanged.
- R5: `mem_space` is 3'b101 (supervisor data) for the three stack writes and both vector reads. It is 3'b110 (supervisor program) for the handler fetch. Bit 2 is high on every cycle.
- R6: `new_pc` is {first vector word, second vector word}, and the handler fetch uses that address.
- R7: `new_ssp` equals the captured stack pointer minus 6.
- R8: `busy` is high from the cycle after the request is accepted until the handler fetch is acknowledged. `done` is high for exactly one cycle, the cycle after that acknowledge, and `busy` is low in that cycle.
- R9: Requests and input changes that arrive while `busy` is high are ignored. The running sequence keeps the values captured at acceptance.
- R10: Once `mem_req` is raised, it stays high with stable `mem_addr`, `mem_we`, `mem_wdata` and `mem_space` until `mem_ack`.
- R11: `mem_we` is 1 only for the three stack writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request, sampled when idle |
| exc_vec | input | 8 | Vector number |
| cur_sr | input | 16 | Current status word |
| cur_pc | input | 32 | Program counter to save |
| cur_ssp | input | 32 | Supervisor stack pointer |
| vbr | input | 32 | Vector table base |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | 1 = write cycle |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_space | output | 3 | Access-space code |
| mem_ack | input | 1 | One-cycle acknowledge of the pending cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Updated status word |
| new_ssp | output | 32 | Updated supervisor stack pointer |

## Verification
The assertions assume that `mem_ack` comes for one cycle only while `mem_req` is high. They also assume that no acknowledge is given in the cycle after an acknowledge, when the next cycle's request has only just been presented. The bench memory model keeps to this rule. It acknowledges after a per-case wait of zero to three cycles and always drops `mem_ack` for the following cycle. While it waits, it checks that the request fields hold still. Read data is a fixed function of the address, so the bench can compute the expected handler address itself.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PCH, ST_PUSH_PCL, ST_PUSH_SR, ST_VEC_HI, ST_VEC_LO, ST_FETCH
  } seq_state_e;

  localparam logic [2:0] SPACE_SUP_DATA = 3'b101;
  localparam logic [2:0] SPACE_SUP_PROG = 3'b110;
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exc_req,
  input  logic       mem_ack,
  output seq_state_e state_o,
  output logic       start_o,
  output logic       busy_o,
  output logic       done_o
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  assign start_o = (state_q == ST_IDLE) && exc_req;
  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE:     if (exc_req) state_d = ST_PUSH_PCH;
      ST_PUSH_PCH: if (mem_ack) state_d = ST_PUSH_PCL;
      ST_PUSH_PCL: if (mem_ack) state_d = ST_PUSH_SR;
      ST_PUSH_SR:  if (mem_ack) state_d = ST_VEC_HI;
      ST_VEC_HI:   if (mem_ack) state_d = ST_VEC_LO;
      ST_VEC_LO:   if (mem_ack) state_d = ST_FETCH;
      ST_FETCH: begin
        if (mem_ack) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH_PCL) |-> $past(state_q) != ST_IDLE);
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 16,
  parameter int VW        = 8,
  parameter int SUP_BIT   = 13,
  parameter int TRACE_BIT = 15,
  parameter int PUSHES    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  seq_state_e    state,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic [VW-1:0] exc_vec,
  input  logic [DW-1:0] cur_sr,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] cur_ssp,
  input  logic [AW-1:0] vbr,
  output logic [DW-1:0] sr_old_q,
  output logic [DW-1:0] sr_new_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] ssp_q,
  output logic [AW-1:0] ssp_new_q,
  output logic [AW-1:0] vaddr_q,
  output logic [AW-1:0] handler_q
);
  localparam int            WB        = DW / 8;
  localparam logic [DW-1:0] SUP_MASK  = DW'(1) << SUP_BIT;
  localparam logic [DW-1:0] TRC_MASK  = DW'(1) << TRACE_BIT;
  localparam logic [AW-1:0] FRAME_SZ  = AW'(PUSHES * WB);

  logic [DW-1:0] vhi_q;
  logic [AW-1:0] vaddr_d;
  logic [DW-1:0] sr_new_d;
  logic          vhi_en, vlo_en;

  assign vaddr_d  = vbr + {{(AW-VW-2){1'b0}}, exc_vec, 2'b00};
  assign sr_new_d = (cur_sr | SUP_MASK) & ~TRC_MASK;
  assign vhi_en   = (state == ST_VEC_HI) && mem_ack;
  assign vlo_en   = (state == ST_VEC_LO) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_old_q  <= '0;
      sr_new_q  <= '0;
      pc_q      <= '0;
      ssp_q     <= '0;
      ssp_new_q <= '0;
      vaddr_q   <= '0;
    end else if (start) begin
      sr_old_q  <= cur_sr;
      sr_new_q  <= sr_new_d;
      pc_q      <= cur_pc;
      ssp_q     <= cur_ssp;
      ssp_new_q <= cur_ssp - FRAME_SZ;
      vaddr_q   <= vaddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vhi_q     <= '0;
      handler_q <= '0;
    end else begin
      if (vhi_en) vhi_q     <= mem_rdata;
      if (vlo_en) handler_q <= {vhi_q, mem_rdata};
    end
  end

  // R4
  sr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sr_new_q[SUP_BIT] && !sr_new_q[TRACE_BIT]);
  // R9
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(sr_old_q) && $stable(pc_q) && $stable(vaddr_q));
endmodule

// File: rtl/exc_bus_mux.sv
module exc_bus_mux
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  seq_state_e    state,
  input  logic [DW-1:0] sr_old,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ssp,
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] handler,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [2:0]    space
);
  localparam logic [AW-1:0] WB = AW'(DW / 8);

  always_comb begin
    req   = 1'b1;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    space = SPACE_SUP_DATA;
    case (state)
      ST_PUSH_PCH: begin we = 1'b1; addr = ssp - WB;      wdata = pc[AW-1:DW]; end
      ST_PUSH_PCL: begin we = 1'b1; addr = ssp - 2 * WB;  wdata = pc[DW-1:0];  end
      ST_PUSH_SR:  begin we = 1'b1; addr = ssp - 3 * WB;  wdata = sr_old;      end
      ST_VEC_HI:   addr = vaddr;
      ST_VEC_LO:   addr = vaddr + WB;
      ST_FETCH:    begin addr = handler; space = SPACE_SUP_PROG; end
      default:     begin req = 1'b0; space = '0; end
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 16,
  parameter int VW        = 8,
  parameter int SUP_BIT   = 13,
  parameter int TRACE_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic [DW-1:0] cur_sr,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] cur_ssp,
  input  logic [AW-1:0] vbr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [2:0]    mem_space,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] new_pc,
  output logic [DW-1:0] new_sr,
  output logic [AW-1:0] new_ssp
);
  seq_state_e    state;
  logic          start;
  logic [DW-1:0] sr_old;
  logic [AW-1:0] pc_sv, ssp_sv, vaddr;

  exc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .mem_ack(mem_ack),
    .state_o(state), .start_o(start), .busy_o(busy), .done_o(done)
  );

  exc_ctx_regs #(
    .AW(AW), .DW(DW), .VW(VW), .SUP_BIT(SUP_BIT), .TRACE_BIT(TRACE_BIT), .PUSHES(3)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .exc_vec(exc_vec), .cur_sr(cur_sr), .cur_pc(cur_pc),
    .cur_ssp(cur_ssp), .vbr(vbr), .sr_old_q(sr_old), .sr_new_q(new_sr),
    .pc_q(pc_sv), .ssp_q(ssp_sv), .ssp_new_q(new_ssp), .vaddr_q(vaddr),
    .handler_q(new_pc)
  );

  exc_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .state(state), .sr_old(sr_old), .pc(pc_sv), .ssp(ssp_sv), .vaddr(vaddr),
    .handler(new_pc), .req(mem_req), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .space(mem_space)
  );

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata) && $stable(mem_space));
  // R5
  sup_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_space[2]);
  // R11
  write_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_space == SPACE_SUP_DATA);
  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);
  // R5
  fetch_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_space == SPACE_SUP_PROG |=> done);
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req;
  logic [7:0]  exc_vec;
  logic [15:0] cur_sr;
  logic [31:0] cur_pc, cur_ssp, vbr;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [2:0]  mem_space;
  logic        busy, done;
  logic [31:0] new_pc, new_ssp;
  logic [15:0] new_sr;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_vec(exc_vec), .cur_sr(cur_sr),
    .cur_pc(cur_pc), .cur_ssp(cur_ssp), .vbr(vbr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_space(mem_space), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .new_pc(new_pc), .new_sr(new_sr),
    .new_ssp(new_ssp)
  );

  function automatic logic [15:0] rd_fn(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h3C5A;
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  localparam int NV = 5;
  localparam logic [7:0]  T_VEC [NV] = '{8'h05, 8'h20, 8'hFF, 8'h00, 8'h80};
  localparam logic [15:0] T_SR  [NV] = '{16'h0700, 16'h8015, 16'hA71F, 16'h2000, 16'h5AA5};
  localparam logic [31:0] T_PC  [NV] = '{32'h0001_2344, 32'hDEAD_BEE0, 32'h0000_0002,
                                         32'hFFFF_FFFE, 32'h1234_5678};
  localparam logic [31:0] T_SSP [NV] = '{32'h0000_8000, 32'h0010_0000, 32'h0000_0004,
                                         32'h7FFF_FFFE, 32'h00C0_0010};
  localparam logic [31:0] T_VBR [NV] = '{32'h0000_0000, 32'h0004_0000, 32'hFFFF_FC00,
                                         32'h0000_1000, 32'h00C0_0000};
  localparam int          T_LAT [NV] = '{0, 2, 1, 3, 0};

  // memory model: acks after lat wait cycles, logs each acknowledged cycle
  int          lat = 0, wait_cnt = 0, n_tx = 0, stab_err = 0;
  logic [31:0] lg_addr  [8];
  logic [15:0] lg_wdata [8];
  logic        lg_we    [8];
  logic [2:0]  lg_space [8];
  logic [31:0] held_addr;

  initial mem_ack = 1'b0;
  always @(negedge clk) begin
    if (mem_ack || !mem_req || !rst_n) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else begin
      if (wait_cnt > 0 && mem_addr != held_addr) stab_err++;
      held_addr = mem_addr;
      if (wait_cnt >= lat) begin
        mem_ack = 1'b1;
        if (n_tx < 8) begin
          lg_addr[n_tx]  = mem_addr;
          lg_wdata[n_tx] = mem_wdata;
          lg_we[n_tx]    = mem_we;
          lg_space[n_tx] = mem_space;
        end
        n_tx++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic run_case(input int i);
    logic [31:0] va, exp_pc;
    int guard;
    @(negedge clk);
    n_tx = 0; stab_err = 0; lat = T_LAT[i];
    exc_vec = T_VEC[i]; cur_sr = T_SR[i]; cur_pc = T_PC[i];
    cur_ssp = T_SSP[i]; vbr = T_VBR[i]; exc_req = 1'b1;
    @(negedge clk);
    chk("R8 busy after accept", busy, 1);
    // R9 noise: request held high, inputs changed while busy
    exc_vec = ~T_VEC[i]; cur_sr = 16'hFFFF; cur_pc = 32'h0; cur_ssp = 32'h0;
    vbr = 32'h5555_0000;
    guard = 0;
    while (!done && guard < 200) begin
      if (mem_req && mem_space == 3'b110) exc_req = 1'b0;
      chk("R8 busy during run", busy, 1);
      @(negedge clk);
      guard++;
    end
    exc_req = 1'b0;
    va     = T_VBR[i] + {22'b0, T_VEC[i], 2'b00};
    exp_pc = {rd_fn(va), rd_fn(va + 32'd2)};
    chk("R8 done seen", done, 1);
    chk("R8 busy low at done", busy, 0);
    chk("R2 cycle count", n_tx, 6);
    chk("R2 push pc hi addr", lg_addr[0], T_SSP[i] - 32'd2);
    chk("R2 push pc hi data", lg_wdata[0], T_PC[i][31:16]);
    chk("R2 push pc lo addr", lg_addr[1], T_SSP[i] - 32'd4);
    chk("R2 push pc lo data", lg_wdata[1], T_PC[i][15:0]);
    chk("R2 push sr addr", lg_addr[2], T_SSP[i] - 32'd6);
    chk("R3 pushed old sr", lg_wdata[2], T_SR[i]);
    chk("R9 R2 vector hi addr", lg_addr[3], va);
    chk("R2 vector lo addr", lg_addr[4], va + 32'd2);
    chk("R6 fetch addr", lg_addr[5], exp_pc);
    for (int k = 0; k < 6; k++) begin
      chk("R11 write enable", lg_we[k], (k < 3) ? 1 : 0);
      chk("R5 space code", lg_space[k], (k == 5) ? 3'b110 : 3'b101);
    end
    chk("R6 new pc", new_pc, exp_pc);
    chk("R4 new sr", new_sr, (T_SR[i] | 16'h2000) & 16'h7FFF);
    chk("R7 new ssp", new_ssp, T_SSP[i] - 32'd6);
    chk("R10 stable while waiting", stab_err, 0);
    @(negedge clk);
    chk("R8 done single cycle", done, 0);
    chk("R9 no restart after done", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; exc_req = 1'b0; exc_vec = '0; cur_sr = '0;
    cur_pc = '0; cur_ssp = '0; vbr = '0;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 mem_req in reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 new_pc after reset", new_pc, 0);
    chk("R1 new_sr after reset", new_sr, 0);
    chk("R1 new_ssp after reset", new_ssp, 0);

    for (int i = 0; i < NV; i++) run_case(i);

    // R1: reset in the middle of a sequence
    lat = 2;
    exc_vec = 8'h11; cur_sr = 16'h0000; cur_pc = 32'h100; cur_ssp = 32'h2000;
    vbr = 32'h0; exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy before mid reset", busy, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 busy cleared by reset", busy, 0);
    chk("R1 mem_req cleared by reset", mem_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 new_ssp cleared by reset", new_ssp, 0);
    chk("R1 idle after mid reset", busy, 0);

    run_case(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule